// File: doc/BRIEF.md
# Slotted Cipher Key Store with Error Flags

This block holds a small set of cipher keys, one per slot, and hands a selected key to the cipher engine when asked. For each slot it tracks whether a key was written cleanly. A write that arrives with a bus-error indication is refused. The refused write leaves that slot unusable and raises a sticky write-error flag.

A read from a slot that holds no clean key still completes. In that case it delivers an all-zero key and raises a sticky read-error flag, so the host can abandon the operation. The host clears each flag by writing 1 to its clear bit. A single clear input drops every key at once, which is what a soft reset of the crypto subsystem uses to leave the store empty.

Top module: `keyvault`

## Requirements
- R1: After reset every slot is unloaded, both flags are 0, `rd_done` is 0 and `rd_key` is all zero.
- R2: A write with `wr_en`=1 and `wr_buserr`=0 stores `wr_key` in slot `wr_slot` and marks that slot loaded from the next cycle.
- R3: A write with `wr_buserr`=1 stores nothing and leaves the addressed slot unloaded, even if it held a key before. It also sets `irq_status[0]` (write error) in the next cycle.
- R4: One cycle after `rd_en`=1, `rd_done` is 1 for exactly one cycle and `rd_key` carries the result. `rd_key` holds its value until the next read.
- R5: Reading an unloaded slot gives `rd_key` equal to zero in every byte and sets `irq_status[1]` (read error) in the next cycle.
- R6: Each flag stays set until the host drives the matching `irq_clr` bit to 1 (bit 0 clears the write error, bit 1 clears the read error). A new error in the same cycle as its clear leaves the flag set.
- R7: `soft_clr`=1 unloads every slot in the next cycle and wins over a write in the same cycle. It does not change the flags.
- R8: A read in the same cycle as a write or `soft_clr` sees the slot state from before that cycle.
- R9: A failed write to one slot leaves the keys and load state of all other slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Unload all slots |
| wr_en | input | 1 | Key write request |
| wr_slot | input | 3 | Slot index for write |
| wr_key | input | 128 | Key to store |
| wr_buserr | input | 1 | Bus error seen during this write |
| rd_en | input | 1 | Key read request |
| rd_slot | input | 3 | Slot index for read |
| rd_key | output | 128 | Key delivered to cipher engine |
| rd_done | output | 1 | Read result valid strobe |
| irq_status | output | 2 | Sticky flags: bit 0 write error, bit 1 read error |
| irq_clr | input | 2 | Write-1-to-clear for the flags |

## Verification
The assertions take every request input as a known 0 or 1 at each clock edge once reset is released. They also take the slot indexes as being within the slot count. No property constrains how writes, reads, clears and flag clears overlap, so each one must hold for any combination in a single cycle. The bench drives every input from a defined value at the falling edge, uses only indexes 0 to 7, and deliberately overlaps a write with a read of the same slot, a write with `soft_clr`, and an error with its own clear.

// File: rtl/keyvault.sv
module keyvault #(
  parameter int SLOTS = 8,
  parameter int KEY_W = 128,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             wr_buserr,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_slot,
  output logic [KEY_W-1:0] rd_key,
  output logic             rd_done,
  output logic [1:0]       irq_status,
  input  logic [1:0]       irq_clr
);

  logic [KEY_W-1:0] mem [SLOTS];
  logic [SLOTS-1:0] valid;

  wire wr_ok   = wr_en & ~wr_buserr;
  wire wr_fail = wr_en & wr_buserr;
  wire rd_hit  = valid[rd_slot];
  wire rd_miss = rd_en & ~rd_hit;

  always_ff @(posedge clk) begin
    if (wr_ok && !soft_clr) mem[wr_slot] <= wr_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid <= '0;
    else if (soft_clr) valid <= '0;
    else if (wr_en)    valid[wr_slot] <= wr_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_done <= 1'b0;
      rd_key  <= '0;
    end else begin
      rd_done <= rd_en;
      if (rd_en) rd_key <= rd_hit ? mem[rd_slot] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_status <= '0;
    else begin
      irq_status[0] <= wr_fail | (irq_status[0] & ~irq_clr[0]);
      irq_status[1] <= rd_miss | (irq_status[1] & ~irq_clr[1]);
    end
  end

endmodule

// File: rtl/keyvault_sva.sv
module keyvault_sva #(
  parameter int SLOTS = 8,
  parameter int KEY_W = 128,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_clr,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_slot,
  input logic             wr_buserr,
  input logic             rd_en,
  input logic [IDX_W-1:0] rd_slot,
  input logic [KEY_W-1:0] rd_key,
  input logic             rd_done,
  input logic [1:0]       irq_status,
  input logic [1:0]       irq_clr,
  input logic [SLOTS-1:0] valid
);

  p_good_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_buserr && !soft_clr |=> valid[$past(wr_slot)]);

  p_bad_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_buserr |=> !valid[$past(wr_slot)] && irq_status[0]);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_done);

  p_no_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_done);

  p_hold_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_key));

  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !valid[rd_slot] |=> rd_key == '0 && irq_status[1]);

  p_sticky_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[0] && !irq_clr[0] |=> irq_status[0]);

  p_sticky_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[1] && !irq_clr[1] |=> irq_status[1]);

  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> valid == '0);

endmodule

bind keyvault keyvault_sva #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_en),
  .wr_slot(wr_slot), .wr_buserr(wr_buserr), .rd_en(rd_en),
  .rd_slot(rd_slot), .rd_key(rd_key), .rd_done(rd_done),
  .irq_status(irq_status), .irq_clr(irq_clr), .valid(valid)
);

// File: tb/keyvault_bench.sv
module keyvault_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         soft_clr = 1'b0, wr_en = 1'b0, wr_buserr = 1'b0, rd_en = 1'b0;
  logic [2:0]   wr_slot = '0, rd_slot = '0;
  logic [127:0] wr_key = '0;
  logic [127:0] rd_key;
  logic         rd_done;
  logic [1:0]   irq_status;
  logic [1:0]   irq_clr = '0;
  int errors = 0, total = 0;

  always #5 clk = ~clk;

  keyvault u_keyvault (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_en),
    .wr_slot(wr_slot), .wr_key(wr_key), .wr_buserr(wr_buserr),
    .rd_en(rd_en), .rd_slot(rd_slot), .rd_key(rd_key), .rd_done(rd_done),
    .irq_status(irq_status), .irq_clr(irq_clr)
  );

  // entry: [15:14] op (0 good write, 1 failed write, 2 read), [13:11] slot,
  // [10:3] key seed, [2] read expected to miss
  localparam logic [15:0] VEC [10] = '{
    {2'd0, 3'd0, 8'd11, 3'b000},
    {2'd2, 3'd0, 8'd11, 3'b000},
    {2'd0, 3'd7, 8'd22, 3'b000},
    {2'd2, 3'd7, 8'd22, 3'b000},
    {2'd2, 3'd3, 8'd0,  3'b100},
    {2'd1, 3'd7, 8'd33, 3'b000},
    {2'd2, 3'd7, 8'd0,  3'b100},
    {2'd2, 3'd0, 8'd11, 3'b000},
    {2'd0, 3'd7, 8'd44, 3'b000},
    {2'd2, 3'd7, 8'd44, 3'b000}
  };

  function automatic logic [127:0] keyf(input logic [7:0] s);
    return {4{32'hA5C3_0000 ^ {24'h0, s} ^ {s, 24'h0}}};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    soft_clr = 0; wr_en = 0; wr_buserr = 0; rd_en = 0; irq_clr = 0;
  endtask

  task automatic clear_flags;
    @(negedge clk); irq_clr = 2'b11;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 rd_done", rd_done, 0);
    chk("R1 rd_key", rd_key, 0);
    chk("R1 flags", irq_status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_en = 1; rd_slot = 3'd4;
    step();
    chk("R1 slot unloaded", irq_status[1], 1);
    clear_flags();

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (VEC[i][15:14] == 2'd2) begin
        rd_en = 1; rd_slot = VEC[i][13:11];
      end else begin
        wr_en = 1; wr_slot = VEC[i][13:11]; wr_key = keyf(VEC[i][10:3]);
        wr_buserr = VEC[i][14];
      end
      step();
      if (VEC[i][15:14] == 2'd2) begin
        chk("R4 rd_done", rd_done, 1);
        chk(VEC[i][2] ? "R5 zero key" : "R2 key", rd_key,
            VEC[i][2] ? 128'h0 : keyf(VEC[i][10:3]));
        chk(VEC[i][2] ? "R5 rd flag" : "R9 no rd flag", irq_status[1], VEC[i][2]);
      end else begin
        chk(VEC[i][14] ? "R3 wr flag" : "R2 no wr flag", irq_status[0], VEC[i][14]);
      end
      clear_flags();
    end

    // R4 single pulse and hold
    @(negedge clk); rd_en = 1; rd_slot = 3'd0;
    step();
    @(negedge clk);
    chk("R4 pulse ends", rd_done, 0);
    chk("R4 key held", rd_key, keyf(8'd11));

    // R6 sticky, per-bit clear, set beats clear
    @(negedge clk); rd_en = 1; rd_slot = 3'd5; wr_en = 1; wr_slot = 3'd6; wr_buserr = 1;
    step();
    repeat (3) @(negedge clk);
    chk("R6 sticky", irq_status, 2'b11);
    @(negedge clk); irq_clr = 2'b01;
    step();
    chk("R6 clear bit0 only", irq_status, 2'b10);
    @(negedge clk); irq_clr = 2'b10; rd_en = 1; rd_slot = 3'd5;
    step();
    chk("R6 set beats clear", irq_status, 2'b10);
    @(negedge clk); irq_clr = 2'b10;
    step();
    chk("R6 cleared", irq_status, 2'b00);

    // R8 read same cycle as write sees old state
    @(negedge clk); wr_en = 1; wr_slot = 3'd5; wr_key = keyf(8'd55); rd_en = 1; rd_slot = 3'd5;
    step();
    chk("R8 pre-write miss", rd_key, 0);
    clear_flags();
    @(negedge clk); rd_en = 1; rd_slot = 3'd5;
    step();
    chk("R8 post-write hit", rd_key, keyf(8'd55));

    // R7 soft clear beats write, keeps flags
    @(negedge clk); wr_en = 1; wr_slot = 3'd6; wr_buserr = 1;
    step();
    @(negedge clk); soft_clr = 1; wr_en = 1; wr_slot = 3'd2; wr_key = keyf(8'd66);
    rd_en = 1; rd_slot = 3'd5;
    step();
    chk("R8 read before clear", rd_key, keyf(8'd55));
    chk("R7 flags kept", irq_status, 2'b01);
    @(negedge clk); rd_en = 1; rd_slot = 3'd2;
    step();
    chk("R7 write lost", rd_key, 0);
    @(negedge clk); rd_en = 1; rd_slot = 3'd0;
    step();
    chk("R7 all unloaded", irq_status[1], 1);
    chk("R7 zero key", rd_key, 0);

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule